// File: doc/BRIEF.md
# Locality-aware thread-block to multiprocessor mapper

This block decides which streaming multiprocessor (SM) runs each thread block of a two-dimensional kernel grid. Before a launch, a strategy value is written into a small mode register. A start pulse then supplies the grid width, the grid height and the number of active SMs. The block walks the grid in row-major order and presents one record per thread block on a valid/ready handshake. Each record holds the x coordinate, the y coordinate and the chosen SM index. A one-cycle done pulse follows the last record.

Three strategies are available:
- Round-robin deals consecutive blocks to consecutive SMs.
- Row grouping gives whole rows of blocks to a single SM, so that blocks which share data along x stay together.
- Column grouping does the same with whole columns.

In the two grouping modes, the rows or columns that cannot be split evenly across the SMs are left over. Those leftover blocks are cut into equal linear chunks. The chunk size and the rows-per-SM quotient are computed once at launch by a sequential divider. The same divider is then reused for each record.

Top module: `cta_map_unit`

## Requirements
- R1: After reset the mode register holds round-robin, and busy_o, err_o, valid_o and done_o are all low. A launch with no prior mode write maps round-robin.
- R2: Mode encoding: 0 is round-robin, 1 groups rows, 2 groups columns, and 3 behaves as round-robin. A write with cfg_we_i in the same cycle as start_i takes effect for that launch.
- R3: Mode writes while busy_o is high are ignored. Both the running grid and the next launch without a write keep the mode that was in force at the previous launch.
- R4: Round-robin: sm_id equals (x + y*gdimx) mod num_sms.
- R5: Row grouping with a = gdimy / num_sms: a block with y < a*num_sms goes to SM y / a.
- R6: Row grouping leftovers: with c = (gdimy - a*num_sms)*gdimx and d = (c+1)/num_sms + 1, a block with y >= a*num_sms goes to SM e / d, where e = x + y*gdimx - a*num_sms*gdimx.
- R7: Column grouping mirrors R5 and R6 with the axes swapped. It uses a = gdimx / num_sms, SM x / a when x < a*num_sms, and otherwise e = y + x*gdimy - a*num_sms*gdimy.
- R8: Records appear in row-major order (x fastest), each block exactly once. A record advances only when valid_o and ready_i are both high. While a record is stalled, it stays unchanged.
- R9: done_o is high for exactly one cycle, in the cycle after the last handshake, and never together with valid_o.
- R10: A start with num_sms, gdimx or gdimy equal to zero sets err_o, produces no record and leaves busy_o low. err_o stays set until the next valid start.
- R11: Every emitted sm_id is below num_sms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_mode_i | input | 2 | Mode value to write |
| start_i | input | 1 | Launch pulse, accepted when idle |
| gdimx_i | input | 9 | Grid width in blocks (1..256) |
| gdimy_i | input | 9 | Grid height in blocks (1..256) |
| num_sms_i | input | 5 | Number of SMs (1..16) |
| ready_i | input | 1 | Consumer accepts the current record |
| busy_o | output | 1 | A grid is being mapped |
| err_o | output | 1 | Last start carried an illegal configuration |
| valid_o | output | 1 | Record present |
| cta_x_o | output | 8 | Block x coordinate |
| cta_y_o | output | 8 | Block y coordinate |
| sm_id_o | output | 4 | Assigned SM index |
| done_o | output | 1 | One-cycle pulse after the last record |

## Verification
A mode write and a launch can fall in the same cycle. Most launches in the sweep are made this way, each with the write strobe and start raised together, and every resulting sm_id is judged against the arithmetic for the newly written mode rather than the previous one. A write can also coincide with a running mapping. This is provoked by pulsing a different mode mid-grid. It is judged correct when the remaining records and a following write-free launch both still follow the original strategy.

// File: rtl/cta_map_pkg.sv
package cta_map_pkg;
  typedef enum logic [1:0] {
    MAP_RR = 2'd0,
    MAP_X  = 2'd1,
    MAP_Y  = 2'd2
  } map_mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_A0, S_A1, S_D0, S_D1, S_C0, S_C1, S_OUT, S_FIN
  } map_state_e;
endpackage

// File: rtl/cta_seq_div.sv
module cta_seq_div #(
  parameter int W = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q, dvs_q, dvd_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    trial;
  logic          fits;

  assign trial  = {rem_q[W-1:0], quo_q[W-1]};
  assign fits   = trial >= {1'b0, dvs_q};
  assign done_o = done_q;
  assign quot_o = quo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        dvd_q <= dividend_i;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? (trial - {1'b0, dvs_q}) : trial;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R6: quotient and remainder reproduce the dividend (feeds chunk math)
  assert_div_exact_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ((2*W)'(quo_q) * (2*W)'(dvs_q) + (2*W)'(rem_q[W-1:0]) == (2*W)'(dvd_q)));
  assert_div_no_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);
endmodule

// File: rtl/cta_map_unit.sv
module cta_map_unit
  import cta_map_pkg::*;
#(
  parameter int NUM_SM_MAX = 16,
  parameter int GRID_MAX   = 256
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  cfg_we_i,
  input  logic [1:0]                            cfg_mode_i,
  input  logic                                  start_i,
  input  logic [$clog2(GRID_MAX+1)-1:0]         gdimx_i,
  input  logic [$clog2(GRID_MAX+1)-1:0]         gdimy_i,
  input  logic [$clog2(NUM_SM_MAX+1)-1:0]       num_sms_i,
  input  logic                                  ready_i,
  output logic                                  busy_o,
  output logic                                  err_o,
  output logic                                  valid_o,
  output logic [$clog2(GRID_MAX)-1:0]           cta_x_o,
  output logic [$clog2(GRID_MAX)-1:0]           cta_y_o,
  output logic [$clog2(NUM_SM_MAX)-1:0]         sm_id_o,
  output logic                                  done_o
);
  localparam int DIM_W = $clog2(GRID_MAX + 1);
  localparam int IDX_W = $clog2(GRID_MAX);
  localparam int NS_W  = $clog2(NUM_SM_MAX + 1);
  localparam int SM_W  = $clog2(NUM_SM_MAX);
  localparam int LIN_W = 2 * DIM_W;
  localparam int DIV_W = LIN_W + 1;

  map_state_e       state_q;
  map_mode_e        run_mode_q;
  logic [1:0]       mode_q, mode_eff;
  logic [DIM_W-1:0] gx_q, gy_q;
  logic [NS_W-1:0]  n_q;
  logic [IDX_W-1:0] x_q, y_q;
  logic [SM_W-1:0]  rr_q, sm_q;
  logic [LIN_W-1:0] a_q, d_q;
  logic             err_q;

  logic [LIN_W-1:0] major_dim, minor_dim, major_idx, region_lim, region_cnt;
  logic [LIN_W-1:0] lin_idx, left_cnt, left_off;
  logic             in_region, last_cta, cfg_bad;
  logic             div_start, div_done;
  logic [DIV_W-1:0] div_dvd, div_dvs, div_quot;

  assign mode_eff  = cfg_we_i ? cfg_mode_i : mode_q;
  assign cfg_bad   = (num_sms_i == '0) || (gdimx_i == '0) || (gdimy_i == '0);
  assign major_dim = (run_mode_q == MAP_Y) ? LIN_W'(gx_q) : LIN_W'(gy_q);
  assign minor_dim = (run_mode_q == MAP_Y) ? LIN_W'(gy_q) : LIN_W'(gx_q);
  assign major_idx = (run_mode_q == MAP_Y) ? LIN_W'(x_q) : LIN_W'(y_q);
  assign region_lim = a_q * LIN_W'(n_q);
  assign region_cnt = region_lim * minor_dim;
  assign left_cnt   = (major_dim - region_lim) * minor_dim;
  assign lin_idx    = (run_mode_q == MAP_Y) ? LIN_W'(y_q) + LIN_W'(x_q) * LIN_W'(gy_q)
                                            : LIN_W'(x_q) + LIN_W'(y_q) * LIN_W'(gx_q);
  assign left_off   = lin_idx - region_cnt;
  assign in_region  = major_idx < region_lim;
  assign last_cta   = ({1'b0, x_q} == gx_q - 1'b1) && ({1'b0, y_q} == gy_q - 1'b1);

  always_comb begin
    div_start = 1'b0;
    div_dvd   = '0;
    div_dvs   = '0;
    unique case (state_q)
      S_A0: begin
        div_start = 1'b1;
        div_dvd   = DIV_W'(major_dim);
        div_dvs   = DIV_W'(n_q);
      end
      S_D0: begin
        div_start = 1'b1;
        div_dvd   = DIV_W'(left_cnt) + 1'b1;
        div_dvs   = DIV_W'(n_q);
      end
      S_C0: begin
        div_start = run_mode_q != MAP_RR;
        div_dvd   = in_region ? DIV_W'(major_idx) : DIV_W'(left_off);
        div_dvs   = in_region ? DIV_W'(a_q) : DIV_W'(d_q);
      end
      default: ;
    endcase
  end

  cta_seq_div #(.W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_dvd),
    .divisor_i  (div_dvs),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      run_mode_q <= MAP_RR;
      mode_q     <= 2'd0;
      gx_q       <= '0;
      gy_q       <= '0;
      n_q        <= '0;
      x_q        <= '0;
      y_q        <= '0;
      rr_q       <= '0;
      sm_q       <= '0;
      a_q        <= '0;
      d_q        <= '0;
      err_q      <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cfg_we_i) mode_q <= cfg_mode_i;
          if (start_i) begin
            if (cfg_bad) begin
              err_q <= 1'b1;
            end else begin
              err_q      <= 1'b0;
              gx_q       <= gdimx_i;
              gy_q       <= gdimy_i;
              n_q        <= num_sms_i;
              x_q        <= '0;
              y_q        <= '0;
              rr_q       <= '0;
              a_q        <= '0;
              d_q        <= '0;
              run_mode_q <= (mode_eff == 2'd1) ? MAP_X :
                            (mode_eff == 2'd2) ? MAP_Y : MAP_RR;
              state_q    <= (mode_eff == 2'd1 || mode_eff == 2'd2) ? S_A0 : S_C0;
            end
          end
        end
        S_A0: state_q <= S_A1;
        S_A1: if (div_done) begin
          a_q     <= LIN_W'(div_quot);
          state_q <= S_D0;
        end
        S_D0: state_q <= S_D1;
        S_D1: if (div_done) begin
          d_q     <= LIN_W'(div_quot) + 1'b1;
          state_q <= S_C0;
        end
        S_C0: begin
          if (run_mode_q == MAP_RR) begin
            sm_q    <= rr_q;
            state_q <= S_OUT;
          end else begin
            state_q <= S_C1;
          end
        end
        S_C1: if (div_done) begin
          sm_q    <= SM_W'(div_quot);
          state_q <= S_OUT;
        end
        S_OUT: if (ready_i) begin
          if (last_cta) begin
            state_q <= S_FIN;
          end else begin
            if ({1'b0, x_q} == gx_q - 1'b1) begin
              x_q <= '0;
              y_q <= y_q + 1'b1;
            end else begin
              x_q <= x_q + 1'b1;
            end
            rr_q    <= ({1'b0, rr_q} == n_q - 1'b1) ? '0 : rr_q + 1'b1;
            state_q <= S_C0;
          end
        end
        S_FIN:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = state_q != S_IDLE;
  assign err_o   = err_q;
  assign valid_o = state_q == S_OUT;
  assign done_o  = state_q == S_FIN;
  assign cta_x_o = x_q;
  assign cta_y_o = y_q;
  assign sm_id_o = sm_q;

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(cta_x_o) && $stable(cta_y_o) && $stable(sm_id_o)));
  assert_sm_in_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({1'b0, sm_id_o} < n_q));
  assert_done_after_hs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!valid_o && $past(valid_o && ready_i)));
  assert_err_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  assert_coord_in_grid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (({1'b0, cta_x_o} < gx_q) && ({1'b0, cta_y_o} < gy_q)));
  assert_mode_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(run_mode_q));
endmodule

// File: tb/tb_cta_map_unit.sv
module tb_cta_map_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic       start = 1'b0;
  logic [8:0] gdimx = '0, gdimy = '0;
  logic [4:0] num_sms = '0;
  logic       ready = 1'b1;
  logic       busy, err, valid, done;
  logic [7:0] cx, cy;
  logic [3:0] sm;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cta_map_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .start_i(start), .gdimx_i(gdimx), .gdimy_i(gdimy), .num_sms_i(num_sms),
    .ready_i(ready), .busy_o(busy), .err_o(err), .valid_o(valid),
    .cta_x_o(cx), .cta_y_o(cy), .sm_id_o(sm), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_sm(input int m, input int gx, input int gy, input int n,
                                input int x, input int y);
    int a, c, d, e, maj, mdim, midx, lin;
    if (m == 0) return (x + y * gx) % n;
    maj  = (m == 2) ? gx : gy;
    mdim = (m == 2) ? gy : gx;
    midx = (m == 2) ? x : y;
    lin  = (m == 2) ? (y + x * gy) : (x + y * gx);
    a = maj / n;
    if (midx < a * n) return midx / a;
    c = (maj - a * n) * mdim;
    d = (c + 1) / n + 1;
    e = lin - a * n * mdim;
    return e / d;
  endfunction

  function automatic string req_of(input int m, input int gx, input int gy, input int n,
                                   input int x, input int y);
    if (m == 0) return "R4";
    if (m == 2) return "R7";
    return (y < (gy / n) * n) ? "R5" : "R6";
  endfunction

  task automatic run_grid(input int m, input int gx, input int gy, input int n,
                          input bit we, input int exp_m, input bit stall, input bit poke);
    int ex = 0, ey = 0, cnt = 0;
    bit poked = 0;
    logic [7:0] hx, hy;
    logic [3:0] hs;
    @(negedge clk);
    cfg_we = we; cfg_mode = 2'(m); start = 1'b1;
    gdimx = 9'(gx); gdimy = 9'(gy); num_sms = 5'(n); ready = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; start = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", int'(busy), 1);
    while (cnt < gx * gy) begin
      @(negedge clk);
      cfg_we = 1'b0;
      if (poke && cnt == 1 && !poked) begin
        cfg_we = 1'b1; cfg_mode = 2'd2; poked = 1;   // R3 write while busy
      end
      if (valid) begin
        chk(cx == 8'(ex) && cy == 8'(ey), "R8 order x", int'(cx), ex);
        chk(int'(sm) == exp_sm(exp_m, gx, gy, n, ex, ey), req_of(exp_m, gx, gy, n, ex, ey),
            int'(sm), exp_sm(exp_m, gx, gy, n, ex, ey));
        chk(int'(sm) < n, "R11", int'(sm), n - 1);
        chk(done === 1'b0, "R9 done with valid", int'(done), 0);
        if (stall && cnt == 1) begin
          hx = cx; hy = cy; hs = sm;
          ready = 1'b0;
          repeat (3) begin
            @(negedge clk);
            chk(valid && cx == hx && cy == hy && sm == hs, "R8 stall hold", int'(valid), 1);
          end
          ready = 1'b1;
        end
        cnt++;
        if (ex == gx - 1) begin ex = 0; ey++; end else ex++;
      end
    end
    cfg_we = 1'b0;
    @(negedge clk);
    chk(done === 1'b1 && valid === 1'b0, "R9 done after last", int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9 single pulse", int'(done), 0);
  endtask

  task automatic bad_start(input int gx, input int gy, input int n);
    @(negedge clk);
    start = 1'b1; gdimx = 9'(gx); gdimy = 9'(gy); num_sms = 5'(n);
    @(negedge clk);
    start = 1'b0;
    chk(err === 1'b1 && busy === 1'b0, "R10 error flag", int'(err), 1);
    repeat (6) begin
      @(negedge clk);
      chk(valid === 1'b0 && busy === 1'b0, "R10 no output", int'(valid), 0);
    end
    chk(err === 1'b1, "R10 error held", int'(err), 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && valid === 1'b0 && done === 1'b0 && err === 1'b0,
        "R1 reset outputs", int'({busy, valid, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && valid === 1'b0, "R1 idle after reset", int'(busy), 0);
    run_grid(1, 3, 2, 2, 1'b0, 0, 1'b0, 1'b0);          // R1 default round-robin
    for (int m = 0; m < 3; m++)
      for (int n = 1; n <= 5; n++)
        for (int gx = 1; gx <= 4; gx++)
          for (int gy = 1; gy <= 5; gy++)
            run_grid(m, gx, gy, n, 1'b1, m, 1'b0, 1'b0); // R2 write with start
    run_grid(3, 4, 3, 3, 1'b1, 0, 1'b0, 1'b0);          // R2 code 3
    run_grid(1, 5, 7, 3, 1'b1, 1, 1'b0, 1'b0);          // R6 uneven leftovers
    run_grid(2, 7, 4, 3, 1'b1, 2, 1'b0, 1'b0);          // R7 uneven leftovers
    run_grid(1, 3, 5, 2, 1'b1, 1, 1'b0, 1'b1);          // R3 poke mid-grid
    run_grid(0, 3, 5, 2, 1'b0, 1, 1'b0, 1'b0);          // R3 mode kept
    run_grid(1, 3, 5, 2, 1'b1, 1, 1'b1, 1'b0);          // R8 stall
    bad_start(3, 3, 0);
    bad_start(0, 3, 2);
    run_grid(0, 2, 2, 2, 1'b1, 0, 1'b0, 1'b0);
    chk(err === 1'b0, "R10 error cleared", int'(err), 0);
    summary();
  end
endmodule